// File: doc/BRIEF.md
# Single-Clock Dual-Port RAM with Selectable Write Modes

This block is a small synchronous memory with two fully symmetric ports, A and B, clocked by one common clock. Each port can read or write any location. Each port has a registered read output that changes only at a rising clock edge. Geometry is set by parameters. Each port has its own compile-time setting that decides what its output shows when that port writes: the word just written, the word that was stored before, or the unchanged earlier result.

When one port writes and the other reads the same location on the same edge, a bypass parameter decides what the reader sees. With bypass off, the reader gets the stored word from before the edge. With bypass on, the incoming write data is forwarded straight to the reader. If both ports write the same location on one edge, port A has priority. A collision flag then reports that the two write words were different.

Top module: `dpram_wm`

## Requirements
- R1: Default geometry is 8 words of 9 bits. Addresses are unsigned binary, 3 bits wide by default (log2 of the depth), and every location can be written and read back independently.
- R2: A word written through either port is returned on either port's read output at the edge where that port samples read enable high with that address. The output is valid from that edge on.
- R3: A port set to write-first that writes on an edge shows the word it wrote on its own output after that edge.
- R4: A port set to read-first that writes on an edge shows the word that was stored at that address before the edge.
- R5: A port set to no-change that writes on an edge keeps its output at its previous value.
- R6: A port with both write enable and read enable low keeps its output at its previous value.
- R7: With bypass off, a port that reads (without writing) the address the other port writes on the same edge gets the word stored before that edge.
- R8: With bypass on, a port that reads (without writing) the address the other port writes on the same edge gets the other port's incoming write data.
- R9: When both ports write the same address on one edge, port A's data is stored. The collision output is 1 for the cycle after that edge only if the two write words differ; otherwise it is 0.
- R10: While reset is asserted (rstN low), both read outputs and the collision output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset for the output registers |
| aAddr | input | AW | Port A address |
| aWe | input | 1 | Port A write enable |
| aRe | input | 1 | Port A read enable |
| aWdata | input | W | Port A write data |
| aRdata | output | W | Port A registered read data |
| bAddr | input | AW | Port B address |
| bWe | input | 1 | Port B write enable |
| bRe | input | 1 | Port B read enable |
| bWdata | input | W | Port B write data |
| bRdata | output | W | Port B registered read data |
| collide | output | 1 | Pulses high when both ports wrote different data to one address |

## Verification
The bench runs two instances side by side. The first has A as write-first, B as read-first and bypass off. The second has A as no-change, B as write-first and bypass on. Identical stimulus drives both, so each same-edge access pattern yields old, new and held results at once. A full fill and readback pass separates address decoding faults from mode faults. Directed cross-port hits on one address separate the forwarded case from the stored-word case. Same-address double writes, with equal and with unequal data, separate the priority behaviour from the flag. Random traffic confined to a few addresses then forces frequent collisions, mixed with idle and read-only cycles.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Per-port behaviour of the read output on a cycle where that port writes
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wrModeT;

  // Source selected for a port's output register on the next edge
  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_MEM  = 2'd1,
    SEL_OWN  = 2'd2,
    SEL_PEER = 2'd3
  } selT;

  typedef struct packed {
    logic wrA;
    logic wrB;
    selT  selA;
    selT  selB;
    logic collide;
  } strobeT;

endpackage

// File: rtl/dpram_wm_ctrl.sv
module dpram_wm_ctrl
  import dpram_pkg::*;
#(
  parameter int     W      = 9,
  parameter int     AW     = 3,
  parameter wrModeT MODE_A = WM_WRITE_FIRST,
  parameter wrModeT MODE_B = WM_WRITE_FIRST,
  parameter bit     BYPASS = 1'b0
) (
  input  logic [AW-1:0] aAddr,
  input  logic          aWe,
  input  logic          aRe,
  input  logic [W-1:0]  aWdata,
  input  logic [AW-1:0] bAddr,
  input  logic          bWe,
  input  logic          bRe,
  input  logic [W-1:0]  bWdata,
  output strobeT        stb
);

  logic sameAddr;
  logic aHitByB;
  logic bHitByA;

  assign sameAddr = (aAddr == bAddr);
  assign aHitByB  = bWe && sameAddr;
  assign bHitByA  = aWe && sameAddr;

  // Output source for one port, given its mode and what the peer does
  function automatic selT pickSel(wrModeT mode, logic we, logic re, logic peerHit);
    selT s;
    if (we) begin
      case (mode)
        WM_WRITE_FIRST: s = SEL_OWN;
        WM_READ_FIRST:  s = SEL_MEM;
        default:        s = SEL_HOLD;
      endcase
    end else if (re) begin
      s = (BYPASS && peerHit) ? SEL_PEER : SEL_MEM;
    end else begin
      s = SEL_HOLD;
    end
    return s;
  endfunction

  always_comb begin
    stb.wrA     = aWe;
    // port A has priority on a shared address
    stb.wrB     = bWe && !(aWe && sameAddr);
    stb.selA    = pickSel(MODE_A, aWe, aRe, aHitByB);
    stb.selB    = pickSel(MODE_B, bWe, bRe, bHitByA);
    stb.collide = aWe && bWe && sameAddr && (aWdata != bWdata);
  end

endmodule

// File: rtl/dpram_wm_datapath.sv
module dpram_wm_datapath
  import dpram_pkg::*;
#(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [AW-1:0] aAddr,
  input  logic [W-1:0]  aWdata,
  input  logic [AW-1:0] bAddr,
  input  logic [W-1:0]  bWdata,
  output logic [W-1:0]  aRdata,
  output logic [W-1:0]  bRdata,
  output logic          collide
);

  localparam int NPORT = 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] addrV [NPORT];
  logic [W-1:0]  wdV   [NPORT];
  selT           selV  [NPORT];

  assign addrV[0] = aAddr;
  assign addrV[1] = bAddr;
  assign wdV[0]   = aWdata;
  assign wdV[1]   = bWdata;
  assign selV[0]  = stb.selA;
  assign selV[1]  = stb.selB;

  // Storage: B first, so A lands last when both strobes hit one word
  always_ff @(posedge clk) begin
    if (stb.wrB) mem[bAddr] <= bWdata;
    if (stb.wrA) mem[aAddr] <= aWdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    logic [W-1:0] qReg;
    logic [W-1:0] nextQ;

    always_comb begin
      case (selV[p])
        SEL_MEM:  nextQ = mem[addrV[p]];
        SEL_OWN:  nextQ = wdV[p];
        SEL_PEER: nextQ = wdV[NPORT-1-p];
        default:  nextQ = qReg;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qReg <= '0;
      else       qReg <= nextQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) collide <= 1'b0;
    else       collide <= stb.collide;
  end

  assign aRdata = gPort[0].qReg;
  assign bRdata = gPort[1].qReg;

endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
  import dpram_pkg::*;
#(
  parameter int     W      = 9,
  parameter int     DEPTH  = 8,
  parameter wrModeT MODE_A = WM_WRITE_FIRST,
  parameter wrModeT MODE_B = WM_WRITE_FIRST,
  parameter bit     BYPASS = 1'b0,
  localparam int    AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] aAddr,
  input  logic          aWe,
  input  logic          aRe,
  input  logic [W-1:0]  aWdata,
  output logic [W-1:0]  aRdata,
  input  logic [AW-1:0] bAddr,
  input  logic          bWe,
  input  logic          bRe,
  input  logic [W-1:0]  bWdata,
  output logic [W-1:0]  bRdata,
  output logic          collide
);

  strobeT stb;

  dpram_wm_ctrl #(
    .W(W), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B), .BYPASS(BYPASS)
  ) uCtrl (
    .aAddr(aAddr), .aWe(aWe), .aRe(aRe), .aWdata(aWdata),
    .bAddr(bAddr), .bWe(bWe), .bRe(bRe), .bWdata(bWdata),
    .stb(stb)
  );

  dpram_wm_datapath #(
    .W(W), .DEPTH(DEPTH), .AW(AW)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .aAddr(aAddr), .aWdata(aWdata),
    .bAddr(bAddr), .bWdata(bWdata),
    .aRdata(aRdata), .bRdata(bRdata), .collide(collide)
  );

endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
  import dpram_pkg::*;
#(
  parameter int     W      = 9,
  parameter int     AW     = 3,
  parameter wrModeT MODE_A = WM_WRITE_FIRST,
  parameter wrModeT MODE_B = WM_WRITE_FIRST,
  parameter bit     BYPASS = 1'b0
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] aAddr,
  input logic          aWe,
  input logic          aRe,
  input logic [W-1:0]  aWdata,
  input logic [W-1:0]  aRdata,
  input logic [AW-1:0] bAddr,
  input logic          bWe,
  input logic          bRe,
  input logic [W-1:0]  bWdata,
  input logic [W-1:0]  bRdata,
  input logic          collide
);

  AST_A_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_A == WM_WRITE_FIRST && aWe) |=> (aRdata == $past(aWdata))); // R3
  AST_B_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_B == WM_WRITE_FIRST && bWe) |=> (bRdata == $past(bWdata))); // R3
  AST_A_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_A == WM_NO_CHANGE && aWe) |=> $stable(aRdata)); // R5
  AST_B_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_B == WM_NO_CHANGE && bWe) |=> $stable(bRdata)); // R5
  AST_A_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!aWe && !aRe) |=> $stable(aRdata)); // R6
  AST_B_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!bWe && !bRe) |=> $stable(bRdata)); // R6
  AST_A_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS && aRe && !aWe && bWe && aAddr == bAddr) |=> (aRdata == $past(bWdata))); // R8
  AST_B_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (BYPASS && bRe && !bWe && aWe && aAddr == bAddr) |=> (bRdata == $past(aWdata))); // R8
  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (aWe && bWe && aAddr == bAddr && aWdata != bWdata) |=> collide); // R9
  AST_COLLIDE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(aWe && bWe && aAddr == bAddr && aWdata != bWdata) |=> !collide); // R9

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (aRdata == '0 && bRdata == '0 && !collide); // R10
    end
  end

endmodule

bind dpram_wm dpram_wm_chk #(
  .W(W), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B), .BYPASS(BYPASS)
) uChk (
  .clk(clk), .rstN(rstN),
  .aAddr(aAddr), .aWe(aWe), .aRe(aRe), .aWdata(aWdata), .aRdata(aRdata),
  .bAddr(bAddr), .bWe(bWe), .bRe(bRe), .bWdata(bWdata), .bRdata(bRdata),
  .collide(collide)
);

// File: tb/tb_dpram_wm.sv
`timescale 1ns/1ps
module tb_dpram_wm;
  import dpram_pkg::*;

  localparam int W = 9;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] aAddr = '0, bAddr = '0;
  logic aWe = 1'b0, aRe = 1'b0, bWe = 1'b0, bRe = 1'b0;
  logic [W-1:0] aWdata = '0, bWdata = '0;
  logic [W-1:0] aQ0, bQ0, aQ1, bQ1;
  logic col0, col1;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Config 0: A write-first, B read-first, bypass off
  dpram_wm #(.W(W), .DEPTH(DEPTH), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
             .BYPASS(1'b0)) dut (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aWe(aWe), .aRe(aRe), .aWdata(aWdata), .aRdata(aQ0),
    .bAddr(bAddr), .bWe(bWe), .bRe(bRe), .bWdata(bWdata), .bRdata(bQ0),
    .collide(col0));

  // Config 1: A no-change, B write-first, bypass on
  dpram_wm #(.W(W), .DEPTH(DEPTH), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST),
             .BYPASS(1'b1)) dutAlt (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aWe(aWe), .aRe(aRe), .aWdata(aWdata), .aRdata(aQ1),
    .bAddr(bAddr), .bWe(bWe), .bRe(bRe), .bWdata(bWdata), .bRdata(bQ1),
    .collide(col1));

  logic [W-1:0] model [DEPTH];
  logic [W-1:0] expA0 = '0, expB0 = '0, expA1 = '0, expB1 = '0;
  logic expCol = 1'b0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expOut(wrModeT mode, bit byp, logic we, logic re,
      logic [AW-1:0] addr, logic [W-1:0] wd, logic peerWe, logic [AW-1:0] peerAddr,
      logic [W-1:0] peerWd, logic [W-1:0] cur);
    if (we) begin
      case (mode)
        WM_WRITE_FIRST: return wd;
        WM_READ_FIRST:  return model[addr];
        default:        return cur;
      endcase
    end
    if (re) begin
      if (byp && peerWe && peerAddr == addr) return peerWd;
      return model[addr];
    end
    return cur;
  endfunction

  function automatic string tagFor(wrModeT mode, bit byp, logic we, logic re,
      logic [AW-1:0] addr, logic peerWe, logic [AW-1:0] peerAddr);
    if (we) begin
      case (mode)
        WM_WRITE_FIRST: return "R3";
        WM_READ_FIRST:  return "R4";
        default:        return "R5";
      endcase
    end
    if (re) begin
      if (peerWe && peerAddr == addr) return byp ? "R8" : "R7";
      return "R2";
    end
    return "R6";
  endfunction

  // Drive one cycle at the falling edge, predict, then compare at the next falling edge
  task automatic step(input logic aw, input logic ar, input logic [AW-1:0] aa,
      input logic [W-1:0] ad, input logic bw, input logic br,
      input logic [AW-1:0] ba, input logic [W-1:0] bd);
    string tA0, tB0, tA1, tB1;
    aWe = aw; aRe = ar; aAddr = aa; aWdata = ad;
    bWe = bw; bRe = br; bAddr = ba; bWdata = bd;
    tA0 = tagFor(WM_WRITE_FIRST, 1'b0, aw, ar, aa, bw, ba);
    tB0 = tagFor(WM_READ_FIRST,  1'b0, bw, br, ba, aw, aa);
    tA1 = tagFor(WM_NO_CHANGE,   1'b1, aw, ar, aa, bw, ba);
    tB1 = tagFor(WM_WRITE_FIRST, 1'b1, bw, br, ba, aw, aa);
    expA0 = expOut(WM_WRITE_FIRST, 1'b0, aw, ar, aa, ad, bw, ba, bd, expA0);
    expB0 = expOut(WM_READ_FIRST,  1'b0, bw, br, ba, bd, aw, aa, ad, expB0);
    expA1 = expOut(WM_NO_CHANGE,   1'b1, aw, ar, aa, ad, bw, ba, bd, expA1);
    expB1 = expOut(WM_WRITE_FIRST, 1'b1, bw, br, ba, bd, aw, aa, ad, expB1);
    expCol = aw && bw && (aa == ba) && (ad != bd);
    if (bw) model[ba] = bd;
    if (aw) model[aa] = ad;   // R9: port A wins a shared address
    @(posedge clk);
    @(negedge clk);
    check({tA0, " dut portA"}, aQ0, expA0);
    check({tB0, " dut portB"}, bQ0, expB0);
    check({tA1, " dutAlt portA"}, aQ1, expA1);
    check({tB1, " dutAlt portB"}, bQ1, expB1);
    check("R9 dut collide", {{(W-1){1'b0}}, col0}, {{(W-1){1'b0}}, expCol});
    check("R9 dutAlt collide", {{(W-1){1'b0}}, col1}, {{(W-1){1'b0}}, expCol});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    check("R10 dut portA", aQ0, '0);
    check("R10 dut portB", bQ0, '0);
    check("R10 dutAlt portA", aQ1, '0);
    check("R10 dutAlt portB", bQ1, '0);
    check("R10 collide", {{(W-1){1'b0}}, col0 | col1}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: fill every location with a distinct word, then read back on both ports
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b0, AW'(i), W'(9'h101 + i * 37), 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, AW'(i), '0, 1'b0, 1'b1, AW'(DEPTH - 1 - i), '0);
      check("R1 readback A", aQ0, W'(9'h101 + i * 37));
      check("R1 readback B", bQ0, W'(9'h101 + (DEPTH - 1 - i) * 37));
    end

    // R7/R8: A writes 3 while B reads 3, then B writes 5 while A reads 5
    step(1'b1, 1'b0, 3'd3, 9'h1A5, 1'b0, 1'b1, 3'd3, '0);
    step(1'b0, 1'b1, 3'd5, '0, 1'b1, 1'b0, 3'd5, 9'h05A);
    // R9: different data to one address, then read it back
    step(1'b1, 1'b0, 3'd2, 9'h0F0, 1'b1, 1'b0, 3'd2, 9'h10F);
    step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 3'd2, '0);
    check("R9 A priority", bQ0, 9'h0F0);
    // R9: identical data, no flag
    step(1'b1, 1'b0, 3'd6, 9'h155, 1'b1, 1'b0, 3'd6, 9'h155);
    // R6: idle cycles hold
    step(1'b0, 1'b0, 3'd1, 9'h1FF, 1'b0, 1'b0, 3'd4, 9'h1FF);
    step(1'b0, 1'b0, 3'd7, 9'h000, 1'b0, 1'b0, 3'd0, 9'h000);

    // Random traffic on a narrow address range to force collisions (R2..R9)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ctl;
      ctl = 4'($urandom);
      step(ctl[0], ($urandom % 4) != 0, AW'($urandom % 3), W'($urandom),
           ctl[1], ($urandom % 4) != 0, AW'($urandom % 3),
           ctl[2] ? W'($urandom) : aWdata);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule